// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a register-mapped timer for a peripheral bus. A prescale counter divides the clock by a programmable amount. Each time it reaches its limit it folds back to zero, and a 32-bit count register steps by one. Four compare registers watch the count. When the count steps onto a compare value, that channel's pending flag is raised. Software clears a flag by writing a one to its bit.

The interrupt line is the OR of the pending flags, each masked by its own enable bit. A control register gates counting. A second control bit holds both counters at zero for as long as it stays set. A mode field must hold its timer setting for the counters to move. Rolling the count past all ones is silent unless a compare register is set to catch it.

Register map: flags 0x0, control 0x1, mode 0x2, count 0x3, prescale limit 0x4, prescale count 0x5, interrupt enables 0x6, compare channel i at 0x8+i. Reads of any other address return zero.

Top module: `match_timer`

## Requirements
- R1: The flags register (0x0) holds channel i's pending flag in bit i, for i = 0..3. Every flag is 0 after reset and reads 1 while its event is pending.
- R2: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R3: Control bit 0 (0x1) is the run bit. While it is 0, the count and the prescale count keep their values. Control bits above bit 1 are dropped on write and read as 0. The control register resets to 0.
- R4: Control bit 1 forces both the count and the prescale count to zero on each rising edge while it is set. Counting resumes from zero once software clears the bit.
- R5: While counting, the prescale count increments on each edge until it equals the prescale limit (0x4). On the next counting edge it returns to 0 and the count increments. A limit of 0 steps the count on every counting edge.
- R6: The mode field (0x2, bits 1:0) resets to 00. Only the value 00 lets the counters advance. Any other value freezes both of them.
- R7: The count rolls over from 0xFFFFFFFF to 0. The rollover sets no flag by itself; a compare register set to 0 catches it.
- R8: A channel's flag is set on the edge where the count steps onto that channel's compare value. A bus write that loads the count never sets a flag.
- R9: The interrupt output is high when any pending flag has its enable bit set in the enables register (0x6, bit i for channel i).
- R10: Bus writes load the count (0x3), the prescale limit (0x4), the prescale count (0x5) and the compare registers (0x8..0xB). A load of a counter takes priority over counting, and the hold bit takes priority over the load. Every register reads back at its address, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
Directed sequences cover several cases:
- A prescale limit of 2 shows the count steps only on the third counting edge.
- A limit of 0 near 0xFFFFFFFF separates the rollover from a compare hit.
- A flag clear timed onto the same edge as a compare hit shows which one wins.
- Run with hold, and a non-timer mode, show when the counters freeze.

Random stimulus then mixes writes to every register with small prescale limits, small compare values and counts near the compare values, so hits, clears and masking overlap in many orders. Every read and the interrupt line are compared each cycle against a bench model built from the requirements.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NCH   = 4,
  parameter int MBASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_FL = AW'(0);
  localparam logic [AW-1:0] A_CT = AW'(1);
  localparam logic [AW-1:0] A_MD = AW'(2);
  localparam logic [AW-1:0] A_TC = AW'(3);
  localparam logic [AW-1:0] A_PS = AW'(4);
  localparam logic [AW-1:0] A_PC = AW'(5);
  localparam logic [AW-1:0] A_IE = AW'(6);

  logic           run, hold;
  logic [1:0]     mode;
  logic [DW-1:0]  tc, pc, psr;
  logic [NCH-1:0] ie, flags, set_f, wr_m;
  logic [DW-1:0]  match [NCH];

  wire wr_fl = we && addr == A_FL;
  wire wr_ct = we && addr == A_CT;
  wire wr_md = we && addr == A_MD;
  wire wr_tc = we && addr == A_TC;
  wire wr_ps = we && addr == A_PS;
  wire wr_pc = we && addr == A_PC;
  wire wr_ie = we && addr == A_IE;

  wire adv  = run && !hold && mode == 2'b00;
  wire tick = adv && pc == psr;
  wire [DW-1:0] tc_nx = tc + 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign set_f[i] = tick && !wr_tc && tc_nx == match[i];
    assign wr_m[i]  = we && addr == AW'(MBASE + i);
    always_ff @(posedge clk)
      if (!rst_n)       match[i] <= '0;
      else if (wr_m[i]) match[i] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; hold <= 1'b0; mode <= 2'b00;
      psr <= '0; ie <= '0; flags <= '0;
    end else begin
      if (wr_ct) {hold, run} <= wdata[1:0];
      if (wr_md) mode <= wdata[1:0];
      if (wr_ps) psr <= wdata;
      if (wr_ie) ie <= wdata[NCH-1:0];
      flags <= (flags & ~(wr_fl ? wdata[NCH-1:0] : '0)) | set_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      tc <= '0;
      pc <= '0;
    end else begin
      if (wr_tc)     tc <= wdata;
      else if (tick) tc <= tc_nx;
      if (wr_pc)     pc <= wdata;
      else if (adv)  pc <= tick ? '0 : pc + 1'b1;
    end
  end

  assign irq = |(flags & ie);

  always_comb begin
    rdata = '0;
    case (addr)
      A_FL: rdata[NCH-1:0] = flags;
      A_CT: rdata[1:0] = {hold, run};
      A_MD: rdata[1:0] = mode;
      A_TC: rdata = tc;
      A_PS: rdata = psr;
      A_PC: rdata = pc;
      A_IE: rdata[NCH-1:0] = ie;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(MBASE + i)) rdata = match[i];
  end

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc == '0 && pc == '0));
  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags)) != '0 |-> $past(tick));
  // R2
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fl && wdata[0] && !set_f[0]) |=> !flags[0]);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !hold && !wr_tc) |=> $stable(tc));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_tc && tc == '1) |=> tc == '0);
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  match_timer dut_i (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .irq(irq));

  logic        m_run, m_hold;
  logic [1:0]  m_mode;
  logic [31:0] m_tc, m_pc, m_psr;
  logic [3:0]  m_ie, m_fl;
  logic [31:0] m_mt [4];

  always @(posedge clk) begin
    logic adv, stp;
    logic [3:0] setv;
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_mode = 0; m_tc = 0; m_pc = 0; m_psr = 0;
      m_ie = 0; m_fl = 0;
      for (int i = 0; i < 4; i++) m_mt[i] = 0;
    end else begin
      adv = m_run && !m_hold && m_mode == 0;
      stp = adv && m_pc == m_psr;
      setv = 0;
      for (int i = 0; i < 4; i++)
        if (stp && !(we && addr == 3) && m_tc + 1 == m_mt[i]) setv[i] = 1;
      m_fl = (m_fl & ~((we && addr == 0) ? wdata[3:0] : 4'h0)) | setv;
      if (m_hold) begin m_tc = 0; m_pc = 0; end
      else begin
        if (we && addr == 3) m_tc = wdata; else if (stp) m_tc = m_tc + 1;
        if (we && addr == 5) m_pc = wdata; else if (adv) m_pc = stp ? 0 : m_pc + 1;
      end
      if (we && addr == 1) {m_hold, m_run} = wdata[1:0];
      if (we && addr == 2) m_mode = wdata[1:0];
      if (we && addr == 4) m_psr = wdata;
      if (we && addr == 6) m_ie = wdata[3:0];
      for (int i = 0; i < 4; i++) if (we && addr == 4'(8 + i)) m_mt[i] = wdata;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      0: return {28'h0, m_fl};
      1: return {30'h0, m_hold, m_run};
      2: return {30'h0, m_mode};
      3: return m_tc;
      4: return m_psr;
      5: return m_pc;
      6: return {28'h0, m_ie};
      8, 9, 10, 11: return m_mt[a[1:0]];
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      0: return "R1/R2/R8";
      1: return "R3/R4";
      2: return "R6";
      3: return "R5/R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); we = 0; end
  endtask

  task automatic rd(input logic [3:0] a, input string r, input logic [31:0] e);
    @(negedge clk); we = 0; addr = a; #1; chk(r, rdata, e);
  endtask

  task automatic rd_irq(input string r, input logic e);
    @(negedge clk); we = 0; #1; chk(r, {31'h0, irq}, {31'h0, e});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(0, "R1", 0); rd(1, "R3", 0); rd(2, "R6", 0); rd(3, "R10", 0);
    rd_irq("R9", 0);
    // R5: limit 2 -> count steps on third counting edge
    wr(4, 2); wr(1, 1); idle(2); wr(1, 0);
    rd(3, "R5", 1); rd(5, "R5", 0);
    idle(2); rd(3, "R3", 1);
    // R7/R8: rollover caught by compare 0, masked irq
    wr(9, 5); wr(10, 100); wr(11, 7); wr(8, 0); wr(4, 0); wr(6, 0);
    wr(3, 32'hFFFF_FFFF); wr(1, 1); wr(1, 0);
    rd(3, "R7", 0); rd(0, "R8", 1); rd_irq("R9", 0);
    wr(6, 1); rd_irq("R9", 1);
    // R2: write-one-to-clear
    wr(0, 0); rd(0, "R2", 1);
    wr(0, 1); rd(0, "R2", 0); rd_irq("R9", 0);
    // R2: set wins over clear on the same edge
    wr(3, 4); wr(6, 2); wr(1, 1); wr(0, 2); wr(1, 0);
    rd(0, "R2", 2); rd(3, "R5", 6); rd_irq("R9", 1);
    wr(0, 15); rd(0, "R2", 0);
    // R4: hold keeps counters at zero
    wr(1, 3); idle(2); rd(3, "R4", 0); rd(5, "R4", 0);
    wr(1, 1); wr(1, 0); rd(3, "R4", 1);
    wr(1, 32'hFC); rd(1, "R3", 0); idle(2); rd(3, "R3", 1);
    // R6: non-timer mode freezes counters
    wr(2, 1); wr(1, 1); idle(3); wr(1, 0);
    rd(3, "R6", 1); rd(2, "R6", 1); wr(2, 0);
    // random phase against the model
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a;
      logic [31:0] d;
      @(negedge clk);
      a = 4'($urandom % 12);
      d = $urandom;
      case (a)
        1: begin d = d % 4; if ($urandom % 8 != 0) d[1] = 0; if ($urandom % 4 != 0) d[0] = 1; end
        2: d = ($urandom % 6 == 0) ? d % 4 : 0;
        3: d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF - (d % 4) : d % 16;
        4: d = d % 4;
        5: d = d % 4;
        8, 9, 10, 11: d = ($urandom % 8 == 0) ? 0 : d % 16;
        default: ;
      endcase
      we = ($urandom % 4 == 0);
      addr = a; wdata = d;
      #1;
      chk(req_of(a), rdata, exp_rd(a));
      chk("R9", {31'h0, irq}, {31'h0, |(m_fl & m_ie)});
    end
    @(negedge clk); we = 0;
    summary();
    $finish;
  end
endmodule